// File: doc/BRIEF.md
# AC-link Codec Register Access Unit

This unit sits on the host side of an AC-link audio controller. Software uses it to read and write the registers of an external codec. The bus side is a set of word registers. The link side is a per-frame slot interface: once per outgoing frame the unit offers a tag word and the two command slots, and once per incoming frame it is shown the received tag word and the two status slots. The serial shifting of those slots is done elsewhere.

To write a codec register, software stores the 16-bit value in the command data register and then writes the index to the command address register with the read flag clear. To read one, software writes only the command address register with the read flag set, then waits for the status flags and reads the captured index and value. Four sticky flags report progress: command index sent, command value sent, status index received and status value received. Each flag stays set until software writes its register with that bit at zero.

Top module: `codec_reg_access`

## Requirements
- R1: After reset every register reads zero, no command is pending, and `tx_tag`, `tx_slot1` and `tx_slot2` are zero.
- R2: The bus word map is: 0 command address, 1 command data, 2 transmit flags, 3 receive flags, 4 status address, 5 status data. Command address keeps bit 19 (1 = read) and the 7-bit index in bits 18:12. Command data keeps the value in bits 19:4. All other bits are ignored on write and read back as zero.
- R3: A write to word 0 arms a command. While it is pending, `tx_tag` is 16'hE000 (frame valid bit 15, slot-1 valid bit 14, slot-2 valid bit 13), `tx_slot1` is the read flag at bit 19 and the index at 18:12, and, for a write, `tx_slot2` is the value at bits 19:4. On the first `frame_strobe` the command is sent and all three outputs return to zero.
- R4: For a read command, `tx_slot2` is zero while the command is pending.
- R5: Sending any command sets transmit flag bit 31. Sending a write command also sets bit 30. Sending a read leaves bit 30 unchanged.
- R6: On `rx_strobe` with `rx_tag` bit 14 set, bits 18:12 of `rx_slot1` are captured as the status index (word 4, bits 18:12). With bit 13 set, bits 19:4 of `rx_slot2` are captured as the status value (word 5, bits 19:4). A new capture overwrites the old value.
- R7: A status index capture sets receive flag bit 22. A status value capture sets bit 21.
- R8: Writing word 2 or word 3 clears every flag whose bit is written 0 and keeps every flag whose bit is written 1. If a flag is set and cleared in the same cycle, it ends up set.
- R9: A write to word 0 while a command is pending replaces that command. If the write falls in a `frame_strobe` cycle, the old command is sent in that frame and the new one stays pending.
- R10: An `rx_strobe` whose tag has bit 14 or bit 13 clear changes neither the matching captured field nor the matching flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| frame_strobe | input | 1 | Outgoing frame boundary; the slots are taken in this cycle |
| tx_tag | output | 16 | Outgoing tag slot |
| tx_slot1 | output | 20 | Outgoing command address slot |
| tx_slot2 | output | 20 | Outgoing command data slot |
| rx_strobe | input | 1 | An incoming frame's slots are valid this cycle |
| rx_tag | input | 16 | Incoming tag slot |
| rx_slot1 | input | 20 | Incoming status address slot |
| rx_slot2 | input | 20 | Incoming status data slot |

## Verification
The hardest cases to reach from the ports are the ones where events collide in a single cycle. One is a frame strobe that sends a command while software writes a flag clear or a new command address. The other is a received tag that marks only one of the two status slots valid. Directed steps force each of these collisions once. The random phase then draws bus writes, frame strobes and receive strobes independently every cycle, so they overlap often, and a bench model built from the requirements predicts each outcome.

// File: rtl/crx_pkg.sv
package crx_pkg;
  localparam int WORD_W  = 32;
  localparam int SLOT_W  = 20;
  localparam int TAG_W   = 16;
  localparam int IDX_W   = 7;
  localparam int VAL_W   = 16;
  localparam int BUS_AW  = 3;
  localparam int IDX_LSB = 12;
  localparam int VAL_LSB = 4;
  localparam int RD_BIT  = 19;
  localparam int TXA_BIT = 31;
  localparam int TXD_BIT = 30;
  localparam int RXA_BIT = 22;
  localparam int RXD_BIT = 21;
  localparam int TAG_FRM = 15;
  localparam int TAG_S1  = 14;
  localparam int TAG_S2  = 13;

  typedef enum logic [BUS_AW-1:0] {
    REG_CADDR = 3'd0,
    REG_CDATA = 3'd1,
    REG_TXF   = 3'd2,
    REG_RXF   = 3'd3,
    REG_SADDR = 3'd4,
    REG_SDATA = 3'd5
  } reg_sel_e;

  function automatic logic [WORD_W-1:0] put_idx(input logic rd, input logic [IDX_W-1:0] idx);
    logic [WORD_W-1:0] w;
    w = '0;
    w[RD_BIT] = rd;
    w[IDX_LSB +: IDX_W] = idx;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] put_val(input logic [VAL_W-1:0] v);
    logic [WORD_W-1:0] w;
    w = '0;
    w[VAL_LSB +: VAL_W] = v;
    return w;
  endfunction

  function automatic logic [IDX_W-1:0] get_idx(input logic [WORD_W-1:0] w);
    return w[IDX_LSB +: IDX_W];
  endfunction

  function automatic logic [VAL_W-1:0] get_val(input logic [WORD_W-1:0] w);
    return w[VAL_LSB +: VAL_W];
  endfunction
endpackage

// File: rtl/crx_cmd_tx.sv
module crx_cmd_tx
  import crx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_caddr,
  input  logic              wr_cdata,
  input  logic              wr_txf,
  input  logic [WORD_W-1:0] wdata,
  input  logic              frame_strobe,
  output logic [TAG_W-1:0]  tx_tag,
  output logic [SLOT_W-1:0] tx_slot1,
  output logic [SLOT_W-1:0] tx_slot2,
  output logic              cmd_rd,
  output logic [IDX_W-1:0]  cmd_idx,
  output logic [VAL_W-1:0]  cmd_val,
  output logic              pending,
  output logic              txa_flag,
  output logic              txd_flag,
  output logic              cmd_fire
);
  logic txa_clr, txd_clr;
  logic [WORD_W-1:0] addr_word, data_word;

  assign cmd_fire = frame_strobe & pending;
  assign txa_clr  = wr_txf & ~wdata[TXA_BIT];
  assign txd_clr  = wr_txf & ~wdata[TXD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_rd   <= 1'b0;
      cmd_idx  <= '0;
      cmd_val  <= '0;
      pending  <= 1'b0;
      txa_flag <= 1'b0;
      txd_flag <= 1'b0;
    end else begin
      if (wr_cdata) cmd_val <= get_val(wdata);
      if (wr_caddr) begin
        cmd_rd  <= wdata[RD_BIT];
        cmd_idx <= get_idx(wdata);
      end
      pending  <= wr_caddr | (pending & ~frame_strobe);
      txa_flag <= cmd_fire | (txa_flag & ~txa_clr);
      txd_flag <= (cmd_fire & ~cmd_rd) | (txd_flag & ~txd_clr);
    end
  end

  assign addr_word = put_idx(cmd_rd, cmd_idx);
  assign data_word = put_val(cmd_val);

  always_comb begin
    tx_tag   = '0;
    tx_slot1 = '0;
    tx_slot2 = '0;
    if (pending) begin
      tx_tag[TAG_FRM] = 1'b1;
      tx_tag[TAG_S1]  = 1'b1;
      tx_tag[TAG_S2]  = 1'b1;
      tx_slot1 = addr_word[SLOT_W-1:0];
      if (!cmd_rd) tx_slot2 = data_word[SLOT_W-1:0];
    end
  end
endmodule

// File: rtl/crx_stat_rx.sv
module crx_stat_rx
  import crx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rxf,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rx_strobe,
  input  logic [TAG_W-1:0]  rx_tag,
  input  logic [SLOT_W-1:0] rx_slot1,
  input  logic [SLOT_W-1:0] rx_slot2,
  output logic [IDX_W-1:0]  st_idx,
  output logic [VAL_W-1:0]  st_val,
  output logic              rxa_flag,
  output logic              rxd_flag,
  output logic              idx_cap,
  output logic              val_cap
);
  logic [WORD_W-1:0] s1_word, s2_word;

  assign idx_cap = rx_strobe & rx_tag[TAG_S1];
  assign val_cap = rx_strobe & rx_tag[TAG_S2];
  assign s1_word = {{(WORD_W-SLOT_W){1'b0}}, rx_slot1};
  assign s2_word = {{(WORD_W-SLOT_W){1'b0}}, rx_slot2};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_idx   <= '0;
      st_val   <= '0;
      rxa_flag <= 1'b0;
      rxd_flag <= 1'b0;
    end else begin
      if (idx_cap) st_idx <= get_idx(s1_word);
      if (val_cap) st_val <= get_val(s2_word);
      rxa_flag <= idx_cap | (rxa_flag & ~(wr_rxf & ~wdata[RXA_BIT]));
      rxd_flag <= val_cap | (rxd_flag & ~(wr_rxf & ~wdata[RXD_BIT]));
    end
  end
endmodule

// File: rtl/crx_rdmux.sv
module crx_rdmux
  import crx_pkg::*;
(
  input  logic [BUS_AW-1:0] addr,
  input  logic              cmd_rd,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [VAL_W-1:0]  cmd_val,
  input  logic              txa_flag,
  input  logic              txd_flag,
  input  logic              rxa_flag,
  input  logic              rxd_flag,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [VAL_W-1:0]  st_val,
  output logic [WORD_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    case (addr)
      REG_CADDR: rdata = put_idx(cmd_rd, cmd_idx);
      REG_CDATA: rdata = put_val(cmd_val);
      REG_TXF: begin
        rdata[TXA_BIT] = txa_flag;
        rdata[TXD_BIT] = txd_flag;
      end
      REG_RXF: begin
        rdata[RXA_BIT] = rxa_flag;
        rdata[RXD_BIT] = rxd_flag;
      end
      REG_SADDR: rdata = put_idx(1'b0, st_idx);
      REG_SDATA: rdata = put_val(st_val);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/codec_reg_access.sv
module codec_reg_access
  import crx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              frame_strobe,
  output logic [TAG_W-1:0]  tx_tag,
  output logic [SLOT_W-1:0] tx_slot1,
  output logic [SLOT_W-1:0] tx_slot2,
  input  logic              rx_strobe,
  input  logic [TAG_W-1:0]  rx_tag,
  input  logic [SLOT_W-1:0] rx_slot1,
  input  logic [SLOT_W-1:0] rx_slot2
);
  logic wr_caddr, wr_cdata, wr_txf, wr_rxf;
  logic cmd_rd, pending, txa_flag, txd_flag, cmd_fire;
  logic rxa_flag, rxd_flag, idx_cap, val_cap;
  logic [IDX_W-1:0] cmd_idx, st_idx;
  logic [VAL_W-1:0] cmd_val, st_val;

  assign wr_caddr = bus_we && (bus_addr == REG_CADDR);
  assign wr_cdata = bus_we && (bus_addr == REG_CDATA);
  assign wr_txf   = bus_we && (bus_addr == REG_TXF);
  assign wr_rxf   = bus_we && (bus_addr == REG_RXF);

  crx_cmd_tx u_tx (
    .clk(clk), .rst_n(rst_n), .wr_caddr(wr_caddr), .wr_cdata(wr_cdata),
    .wr_txf(wr_txf), .wdata(bus_wdata), .frame_strobe(frame_strobe),
    .tx_tag(tx_tag), .tx_slot1(tx_slot1), .tx_slot2(tx_slot2),
    .cmd_rd(cmd_rd), .cmd_idx(cmd_idx), .cmd_val(cmd_val), .pending(pending),
    .txa_flag(txa_flag), .txd_flag(txd_flag), .cmd_fire(cmd_fire)
  );

  crx_stat_rx u_rx (
    .clk(clk), .rst_n(rst_n), .wr_rxf(wr_rxf), .wdata(bus_wdata),
    .rx_strobe(rx_strobe), .rx_tag(rx_tag), .rx_slot1(rx_slot1), .rx_slot2(rx_slot2),
    .st_idx(st_idx), .st_val(st_val), .rxa_flag(rxa_flag), .rxd_flag(rxd_flag),
    .idx_cap(idx_cap), .val_cap(val_cap)
  );

  crx_rdmux u_mux (
    .addr(bus_addr), .cmd_rd(cmd_rd), .cmd_idx(cmd_idx), .cmd_val(cmd_val),
    .txa_flag(txa_flag), .txd_flag(txd_flag), .rxa_flag(rxa_flag), .rxd_flag(rxd_flag),
    .st_idx(st_idx), .st_val(st_val), .rdata(bus_rdata)
  );
endmodule

// File: rtl/crx_chk.sv
module crx_chk
  import crx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_fire,
  input logic              cmd_rd,
  input logic              wr_caddr,
  input logic              wr_rxf,
  input logic [WORD_W-1:0] bus_wdata,
  input logic              txa_flag,
  input logic              txd_flag,
  input logic              rxa_flag,
  input logic              rx_strobe,
  input logic [TAG_W-1:0]  rx_tag,
  input logic [SLOT_W-1:0] rx_slot1,
  input logic [IDX_W-1:0]  st_idx,
  input logic [TAG_W-1:0]  tx_tag
);
  // R5
  txa_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> txa_flag);
  // R5
  rd_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_rd && !txd_flag) |=> !txd_flag);
  // R3
  tag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !wr_caddr) |=> (tx_tag == '0));
  // R6
  sidx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && rx_tag[TAG_S1]) |=> (st_idx == $past(rx_slot1[IDX_LSB +: IDX_W])));
  // R8
  rxa_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxa_flag && !(wr_rxf && !bus_wdata[RXA_BIT])) |=> rxa_flag);
  // R10
  sidx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_strobe && rx_tag[TAG_S1]) |=> $stable(st_idx));
endmodule

bind codec_reg_access crx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .cmd_rd(cmd_rd),
  .wr_caddr(wr_caddr), .wr_rxf(wr_rxf), .bus_wdata(bus_wdata),
  .txa_flag(txa_flag), .txd_flag(txd_flag), .rxa_flag(rxa_flag),
  .rx_strobe(rx_strobe), .rx_tag(rx_tag), .rx_slot1(rx_slot1),
  .st_idx(st_idx), .tx_tag(tx_tag)
);

// File: tb/tb_codec_reg_access.sv
`timescale 1ns/1ps
module tb_codec_reg_access;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0, frame_strobe = 1'b0, rx_strobe = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [15:0] tx_tag, rx_tag = '0;
  logic [19:0] tx_slot1, tx_slot2, rx_slot1 = '0, rx_slot2 = '0;
  int checks = 0, errors = 0;

  // model state
  logic m_pend = 0, m_rd = 0, m_txa = 0, m_txd = 0, m_rxa = 0, m_rxd = 0;
  logic [6:0] m_idx = 0, m_sidx = 0;
  logic [15:0] m_val = 0, m_sval = 0;

  always #2.5 clk = ~clk;

  codec_reg_access dut (.*);

  function automatic logic [31:0] w_addr(input logic rd, input logic [6:0] i);
    return (32'(rd) << 19) | (32'(i) << 12);
  endfunction
  function automatic logic [31:0] w_val(input logic [15:0] v);
    return 32'(v) << 4;
  endfunction
  function automatic logic [31:0] exp_word(input int a);
    case (a)
      0: return w_addr(m_rd, m_idx);
      1: return w_val(m_val);
      2: return (32'(m_txa) << 31) | (32'(m_txd) << 30);
      3: return (32'(m_rxa) << 22) | (32'(m_rxd) << 21);
      4: return w_addr(1'b0, m_sidx);
      5: return w_val(m_sval);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_tx();
    logic [31:0] e1, e2;
    e1 = m_pend ? w_addr(m_rd, m_idx) : 32'h0;
    e2 = (m_pend && !m_rd) ? w_val(m_val) : 32'h0;
    check("R3 tag", 32'(tx_tag), m_pend ? 32'hE000 : 32'h0);
    check("R3 slot1", 32'(tx_slot1), e1);
    check(m_rd ? "R4 slot2" : "R3 slot2", 32'(tx_slot2), e2);
  endtask

  task automatic check_regs();
    for (int a = 0; a < 6; a++) begin
      bus_addr = 3'(a);
      #0.5;
      case (a)
        0, 1: check("R2 cmd reg", bus_rdata, exp_word(a));
        2: check("R5 tx flags", bus_rdata, exp_word(a));
        3: check("R7 rx flags", bus_rdata, exp_word(a));
        default: check("R6 status reg", bus_rdata, exp_word(a));
      endcase
    end
  endtask

  // one clock cycle with the given inputs; model advanced from the requirements
  task automatic step(input logic we, input logic [2:0] a, input logic [31:0] wd,
                      input logic fs, input logic rs, input logic [15:0] rt,
                      input logic [19:0] r1, input logic [19:0] r2);
    logic n_pend, n_rd, n_txa, n_txd, n_rxa, n_rxd, fire;
    logic [6:0] n_idx, n_sidx;
    logic [15:0] n_val, n_sval;
    bus_we = we; bus_addr = a; bus_wdata = wd; frame_strobe = fs;
    rx_strobe = rs; rx_tag = rt; rx_slot1 = r1; rx_slot2 = r2;
    fire = fs && m_pend;
    n_pend = (we && a == 0) || (m_pend && !fs);                       // R3 R9
    n_rd = (we && a == 0) ? wd[19] : m_rd;
    n_idx = (we && a == 0) ? wd[18:12] : m_idx;
    n_val = (we && a == 1) ? wd[19:4] : m_val;
    n_txa = fire ? 1'b1 : ((we && a == 2 && !wd[31]) ? 1'b0 : m_txa);  // R5 R8
    n_txd = (fire && !m_rd) ? 1'b1 : ((we && a == 2 && !wd[30]) ? 1'b0 : m_txd);
    n_sidx = (rs && rt[14]) ? r1[18:12] : m_sidx;                     // R6 R10
    n_sval = (rs && rt[13]) ? r2[19:4] : m_sval;
    n_rxa = (rs && rt[14]) ? 1'b1 : ((we && a == 3 && !wd[22]) ? 1'b0 : m_rxa); // R7
    n_rxd = (rs && rt[13]) ? 1'b1 : ((we && a == 3 && !wd[21]) ? 1'b0 : m_rxd);
    @(posedge clk);
    @(negedge clk);
    m_pend = n_pend; m_rd = n_rd; m_idx = n_idx; m_val = n_val; m_txa = n_txa;
    m_txd = n_txd; m_sidx = n_sidx; m_sval = n_sval; m_rxa = n_rxa; m_rxd = n_rxd;
    bus_we = 0; frame_strobe = 0; rx_strobe = 0; rx_tag = '0;
    check_tx();
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check_tx();
    check_regs();
    rst_n = 1;
    idle();
    // R2: field layout, stray bits dropped
    step(1, 1, 32'hFFFA_BCDF, 0, 0, 0, 0, 0);
    step(1, 0, 32'hFF75_5FFF & ~32'h0008_0000, 0, 0, 0, 0, 0);
    check_regs();
    // R3 write command pending, then sent
    idle();
    step(0, 0, 0, 1, 0, 0, 0, 0);
    check_regs();   // R5: both flags set
    // clear both, then R4 read request
    step(1, 2, 32'h0, 0, 0, 0, 0, 0);
    step(1, 0, w_addr(1, 7'h12), 0, 0, 0, 0, 0);
    check("R4 slot2 zero", 32'(tx_slot2), 32'h0);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    check_regs();   // R5: bit 31 only
    // R8: write one keeps, set wins over clear
    step(1, 2, 32'h8000_0000, 0, 0, 0, 0, 0);
    check("R8 keep", 32'(m_txa), 32'h1);
    step(1, 0, w_addr(0, 7'h33), 0, 0, 0, 0, 0);
    step(1, 2, 32'h0, 1, 0, 0, 0, 0);
    check_regs();
    // R9: replace pending; address write in strobe cycle
    step(1, 0, w_addr(0, 7'h01), 0, 0, 0, 0, 0);
    step(1, 0, w_addr(1, 7'h02), 0, 0, 0, 0, 0);
    step(1, 0, w_addr(0, 7'h03), 1, 0, 0, 0, 0);
    check("R9 still pending", 32'(tx_tag), 32'hE000);
    idle();
    // R6 R7 capture, R10 ignored slot
    step(0, 0, 0, 0, 1, 16'h6000, 20'h5A000, 20'hBEEF5);
    check_regs();
    step(1, 3, 32'h0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 16'h8000, 20'h7F000, 20'h12340);
    check_regs();   // R10: nothing changed
    step(0, 0, 0, 0, 1, 16'h4000, 20'h33000, 20'hFFFF0);
    check_regs();   // R10: only index side
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic we, fs, rs;
      logic [2:0] a;
      logic [31:0] wd;
      we = ($urandom % 3) == 0;
      a = 3'($urandom % 7);
      wd = $urandom;
      fs = ($urandom % 4) == 0;
      rs = ($urandom % 4) == 0;
      step(we, a, wd, fs, rs, 16'($urandom), 20'($urandom), 20'($urandom));
      if (n % 8 == 0) check_regs();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule